// File: doc/BRIEF.md
# Programmable General-Purpose Pin Chip-Select Generator

This block drives four general-purpose pins that serve power control and device selection. Each pin holds its own configuration word, written through a simple register write port. The word sets the pin's operating mode, a static level, a direction bit, and an address base and compare mask. A pin can hold a fixed level, act as an active-low chip select decoded from the I/O address, or act as a decode that is only active during an I/O read or an I/O write strobe.

The pins do not all have the same abilities. Pins 0 and 1 may be turned into inputs. Their sampled level is then returned on the readback bus. Pins 2 and 3 always drive. Only pins 1 and 3 can be qualified by the read strobe, and only pins 0 and 2 by the write strobe. If a pin is given a strobe mode it does not support, it falls back to plain decode. The decode paths are combinational from the address and strobes. Configuration takes effect one cycle after it is written. Readback is registered.

Top module: `gpcs_top`

## Requirements
- R1: While reset is held and on the cycle after it, every pin_out is 1. Pins 0 and 1 are inputs (pin_oe bits 1:0 = 0) and pins 2 and 3 drive (pin_oe bits 3:2 = 1). After reset every pin is in static mode with level 1, base 0 and mask 0.
- R2: When cfg_we is 1 at a clock edge, cfg_wdata is stored as the configuration of the pin chosen by cfg_pin, and it governs that pin from the next cycle. The word has these fields: bits [1:0] mode, bit [2] static level, bit [3] input direction, bits [19:4] base, bits [35:20] mask.
- R3: In mode 0 (static), an output pin drives its static level bit.
- R4: In mode 1 (decode), an output pin drives 0 exactly when ((io_addr XOR base) AND mask) is zero, and drives 1 otherwise.
- R5: In mode 2 (read-gated), pins 1 and 3 drive 0 only when the address matches and io_rd is 1. Pins 0 and 2 in mode 2 behave as in mode 1.
- R6: In mode 3 (write-gated), pins 0 and 2 drive 0 only when the address matches and io_wr is 1. Pins 1 and 3 in mode 3 behave as in mode 1.
- R7: A direction bit of 1 on pin 0 or 1 makes that pin an input: its pin_oe is 0 and its pin_out is 1. With the bit at 0, pin_oe is 1. On pins 2 and 3 the direction bit is ignored and pin_oe is always 1.
- R8: rd_level bit i equals the pin_in bit i sampled at the previous clock edge when pin i is an input, and is 0 when pin i is an output.
- R9: A mask bit of 0 excludes that address bit from the compare, so an all-zero mask matches every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O cycle address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_pin | input | 2 | Pin whose configuration is written |
| cfg_wdata | input | 36 | Configuration word |
| pin_in | input | 4 | Sampled pad levels |
| pin_out | output | 4 | Pin drive values, chip selects active low |
| pin_oe | output | 4 | Pin output enables |
| rd_level | output | 4 | Readback of input pin levels |

## Verification
Some properties are checked on every cycle. The reset state of the pins. The output enables of pins 2 and 3, which are always driven. An input pin being released and held high. The readback staying at zero for pins in output mode. A gated select never being asserted without its strobe. A configuration write landing in the selected pin. Other behaviour can only be shown by the bench's scenarios, because the expected value depends on the configuration: whether a given address produces a match under a mask, the fallback of an unsupported strobe mode to plain decode, and the one-cycle delay of the readback path.

// File: rtl/gpcs_pkg.sv
package gpcs_pkg;
    parameter int GP_NPIN   = 4;
    parameter int GP_ADDR_W = 16;
    localparam int GP_IDX_W = $clog2(GP_NPIN);

    typedef enum logic [1:0] {
        MODE_STATIC = 2'b00,
        MODE_DECODE = 2'b01,
        MODE_RDGATE = 2'b10,
        MODE_WRGATE = 2'b11
    } gp_mode_e;

    typedef struct packed {
        logic [GP_ADDR_W-1:0] mask;
        logic [GP_ADDR_W-1:0] base;
        logic                 dir_in;
        logic                 level;
        gp_mode_e             mode;
    } pin_cfg_t;

    localparam int GP_CFG_W = $bits(pin_cfg_t);

    // Pins 0 and 1 can be turned into inputs.
    function automatic logic can_input(input int idx);
        return idx < 2;
    endfunction

    // Odd pins take the read strobe, even pins the write strobe.
    function automatic logic rd_gated(input int idx);
        return (idx % 2) == 1;
    endfunction

    function automatic pin_cfg_t cfg_reset(input int idx);
        pin_cfg_t c;
        c        = '0;
        c.mode   = MODE_STATIC;
        c.level  = 1'b1;
        c.dir_in = can_input(idx);
        return c;
    endfunction
endpackage

// File: rtl/gpcs_cfg_bank.sv
module gpcs_cfg_bank
    import gpcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [GP_IDX_W-1:0] sel,
    input  pin_cfg_t            wdata,
    output pin_cfg_t            cfg [GP_NPIN]
);
    for (genvar g = 0; g < GP_NPIN; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= cfg_reset(g);
            end else if (we && sel == GP_IDX_W'(g)) begin
                cfg[g] <= wdata;
            end
        end

        // R2
        cfg_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (we && sel == GP_IDX_W'(g)) |=> (cfg[g] == $past(wdata)));
    end
endmodule

// File: rtl/gpcs_addr_match.sv
module gpcs_addr_match
    import gpcs_pkg::*;
(
    input  logic [GP_ADDR_W-1:0] addr,
    input  logic [GP_ADDR_W-1:0] base,
    input  logic [GP_ADDR_W-1:0] mask,
    output logic                 hit
);
    logic [GP_ADDR_W-1:0] diff;
    always_comb begin
        diff = (addr ^ base) & mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/gpcs_pin_drive.sv
module gpcs_pin_drive
    import gpcs_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_cfg_t             cfg,
    input  logic [GP_ADDR_W-1:0] addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 rd_bit
);
    localparam logic CAN_IN = can_input(IDX);
    localparam logic RD_G   = rd_gated(IDX);

    logic     hit;
    logic     strobe;
    logic     in_mode;
    logic     drv;
    gp_mode_e eff_mode;

    gpcs_addr_match u_match (
        .addr (addr),
        .base (cfg.base),
        .mask (cfg.mask),
        .hit  (hit)
    );

    always_comb begin
        eff_mode = cfg.mode;
        if (RD_G && cfg.mode == MODE_WRGATE) eff_mode = MODE_DECODE;
        if (!RD_G && cfg.mode == MODE_RDGATE) eff_mode = MODE_DECODE;
        strobe  = RD_G ? io_rd : io_wr;
        in_mode = CAN_IN & cfg.dir_in;
        case (eff_mode)
            MODE_STATIC: drv = cfg.level;
            MODE_DECODE: drv = ~hit;
            default:     drv = ~(hit & strobe);
        endcase
        pin_out = in_mode ? 1'b1 : drv;
        pin_oe  = ~in_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_bit <= 1'b0;
        else     rd_bit <= in_mode & pin_in;
    end

    // R7
    input_released_chk: assert property (@(posedge clk) disable iff (rst)
        (CAN_IN && cfg.dir_in) |-> (!pin_oe && pin_out));

    // R8
    readback_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(CAN_IN && cfg.dir_in) |-> !rd_bit);

    // R5
    rd_gate_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (RD_G && cfg.mode == MODE_RDGATE && !pin_out) |-> io_rd);

    // R6
    wr_gate_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!RD_G && cfg.mode == MODE_WRGATE && !pin_out) |-> io_wr);
endmodule

// File: rtl/gpcs_top.sv
module gpcs_top
    import gpcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GP_ADDR_W-1:0] io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 cfg_we,
    input  logic [GP_IDX_W-1:0]  cfg_pin,
    input  logic [GP_CFG_W-1:0]  cfg_wdata,
    input  logic [GP_NPIN-1:0]   pin_in,
    output logic [GP_NPIN-1:0]   pin_out,
    output logic [GP_NPIN-1:0]   pin_oe,
    output logic [GP_NPIN-1:0]   rd_level
);
    pin_cfg_t cfg [GP_NPIN];

    gpcs_cfg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_pin),
        .wdata (pin_cfg_t'(cfg_wdata)),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < GP_NPIN; g++) begin : g_pin
        gpcs_pin_drive #(.IDX(g)) u_drv (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg[g]),
            .addr    (io_addr),
            .io_rd   (io_rd),
            .io_wr   (io_wr),
            .pin_in  (pin_in[g]),
            .pin_out (pin_out[g]),
            .pin_oe  (pin_oe[g]),
            .rd_bit  (rd_level[g])
        );

        if (!can_input(g)) begin : g_outonly
            // R7
            out_only_oe_chk: assert property (@(posedge clk) disable iff (rst)
                pin_oe[g]);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pin_out == '1 && pin_oe == 4'b1100));
endmodule

// File: tb/sim_gpcs_top.sv
`timescale 1ns/1ps
module sim_gpcs_top;
    import gpcs_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic        io_rd, io_wr, cfg_we;
    logic [1:0]  cfg_pin;
    logic [35:0] cfg_wdata;
    logic [3:0]  pin_in, pin_out, pin_oe, rd_level;

    always #2.5 clk = ~clk;

    gpcs_top u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_wdata(cfg_wdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .rd_level(rd_level)
    );

    int total = 0;
    int bad   = 0;

    logic [1:0]  m_mode [4];
    logic        m_lvl  [4];
    logic        m_dir  [4];
    logic [15:0] m_base [4];
    logic [15:0] m_mask [4];
    logic [3:0]  prev_in;
    logic        have_prev;

    function automatic logic f_in_mode(int i);
        return (i < 2) && m_dir[i];
    endfunction

    function automatic logic f_out(int i, logic [15:0] a, logic rd, logic wr);
        logic hit;
        hit = (((a ^ m_base[i]) & m_mask[i]) == 16'h0);
        if (f_in_mode(i)) return 1'b1;
        case (m_mode[i])
            2'd0: return m_lvl[i];
            2'd1: return !hit;
            2'd2: return (i % 2 == 1) ? !(hit && rd) : !hit;
            default: return (i % 2 == 0) ? !(hit && wr) : !hit;
        endcase
    endfunction

    function automatic string req_of(int i);
        if (f_in_mode(i)) return "R7";
        case (m_mode[i])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(int p, logic [1:0] mode, logic lvl, logic dir,
                             logic [15:0] base, logic [15:0] mask);
        m_mode[p] = mode; m_lvl[p] = lvl; m_dir[p] = dir;
        m_base[p] = base; m_mask[p] = mask;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_pin   = 2'(p);
        cfg_wdata = {mask, base, dir, lvl, mode};
        @(negedge clk);
        cfg_we    = 1'b0;
        have_prev = 1'b0;
    endtask

    task automatic step(logic [15:0] a, logic rd, logic wr, logic [3:0] pins);
        @(negedge clk);
        if (have_prev) begin
            for (int i = 0; i < 4; i++)
                chk("R8 readback", rd_level[i], f_in_mode(i) ? prev_in[i] : 1'b0);
        end
        io_addr = a; io_rd = rd; io_wr = wr; pin_in = pins;
        #1;
        for (int i = 0; i < 4; i++) begin
            chk(req_of(i), pin_out[i], f_out(i, a, rd, wr));
            chk("R7 oe", pin_oe[i], !f_in_mode(i));
        end
        prev_in   = pins;
        have_prev = 1'b1;
    endtask

    function automatic logic [15:0] pick_addr();
        int k;
        k = int'($urandom_range(0, 3));
        if ($urandom_range(0, 1) == 1) return m_base[k] ^ (16'($urandom) & ~m_mask[k]);
        return 16'($urandom);
    endfunction

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] masks [4];
        void'($urandom(32'd4711));
        masks[0] = 16'hFFFF; masks[1] = 16'hFFF0; masks[2] = 16'h0000; masks[3] = 16'hFF00;
        for (int i = 0; i < 4; i++) begin
            m_mode[i] = 2'd0; m_lvl[i] = 1'b1; m_dir[i] = (i < 2);
            m_base[i] = '0; m_mask[i] = '0;
        end
        have_prev = 1'b0; prev_in = '0;
        rst = 1'b1; cfg_we = 1'b0; cfg_pin = '0; cfg_wdata = '0;
        io_addr = '0; io_rd = 1'b0; io_wr = 1'b0; pin_in = 4'b0011;
        repeat (3) @(negedge clk);
        chk("R1 reset out", pin_out, 4'hF);
        chk("R1 reset oe", pin_oe, 4'b1100);
        chk("R1 reset readback", rd_level, 4'h0);
        rst = 1'b0;
        step(16'h1234, 1'b1, 1'b1, 4'b0000);
        chk("R1 post reset out", pin_out, 4'hF);

        // R2 / R3: static levels on output pins
        write_cfg(2, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(16'h0000, 1'b0, 1'b0, 4'b0101);
        chk("R2 write applied", pin_out[2], 1'b0);
        write_cfg(0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(16'h0000, 1'b0, 1'b0, 4'b1111);

        // R4 / R9: decode with partial mask
        write_cfg(0, 2'd1, 1'b1, 1'b0, 16'h0300, 16'hFFF0);
        step(16'h0305, 1'b0, 1'b0, 4'b0000);
        chk("R9 masked match", pin_out[0], 1'b0);
        step(16'h0315, 1'b0, 1'b0, 4'b0000);
        chk("R4 miss", pin_out[0], 1'b1);

        // R5: read gating on pin 1, unsupported on pin 0
        write_cfg(1, 2'd2, 1'b1, 1'b0, 16'h0400, 16'hFFFF);
        step(16'h0400, 1'b1, 1'b0, 4'b0000);
        chk("R5 rd gated hit", pin_out[1], 1'b0);
        step(16'h0400, 1'b0, 1'b1, 4'b0000);
        chk("R5 wrong strobe", pin_out[1], 1'b1);
        write_cfg(0, 2'd2, 1'b1, 1'b0, 16'h0500, 16'hFFFF);
        step(16'h0500, 1'b0, 1'b0, 4'b0000);
        chk("R5 pin0 falls back to decode", pin_out[0], 1'b0);

        // R6: write gating on pin 2, unsupported on pin 3
        write_cfg(2, 2'd3, 1'b1, 1'b0, 16'h0600, 16'hFFFF);
        write_cfg(3, 2'd3, 1'b1, 1'b0, 16'h0600, 16'hFFFF);
        step(16'h0600, 1'b0, 1'b1, 4'b0000);
        chk("R6 wr gated hit", pin_out[2], 1'b0);
        step(16'h0600, 1'b1, 1'b0, 4'b0000);
        chk("R6 no write strobe", pin_out[2], 1'b1);
        chk("R6 pin3 falls back to decode", pin_out[3], 1'b0);

        // R7: direction bit
        write_cfg(3, 2'd1, 1'b1, 1'b1, 16'h0600, 16'hFFFF);
        write_cfg(1, 2'd1, 1'b1, 1'b1, 16'h0400, 16'hFFFF);
        step(16'h0400, 1'b0, 1'b0, 4'b1010);
        chk("R7 pin3 dir ignored", pin_oe[3], 1'b1);
        chk("R7 pin1 released", pin_oe[1], 1'b0);
        step(16'h0000, 1'b0, 1'b0, 4'b0000);
        chk("R8 pin1 sampled", rd_level[1], 1'b1);

        // R9: all-zero mask
        write_cfg(2, 2'd1, 1'b1, 1'b0, 16'hABCD, 16'h0000);
        step(16'h1357, 1'b0, 1'b0, 4'b0000);
        chk("R9 zero mask always hits", pin_out[2], 1'b0);

        // Random configurations and traffic
        for (int r = 0; r < 40; r++) begin
            for (int p = 0; p < 4; p++)
                write_cfg(p, 2'($urandom), 1'($urandom), 1'($urandom),
                          16'($urandom_range(0, 7)) << 8,
                          masks[$urandom_range(0, 3)]);
            for (int c = 0; c < 30; c++)
                step(pick_addr(), 1'($urandom), 1'($urandom), 4'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule